// File: doc/BRIEF.md
# Transmit Rail Input Interface

This block is the system-side transmit input stage for a single line channel. It takes transmit data in one of three formats and produces registered line pulse commands for the line driver that follows it. The three formats are single-rail NRZ, dual-rail NRZ and dual-rail RZ. In the two NRZ formats the data pins are sampled when a nominal 2.048 MHz transmit clock makes its chosen edge. In the RZ format there is no transmit clock. The pin that carries the clock in the NRZ formats carries the negative rail instead, and a pulse is taken whenever a rail turns active.

All pins are asynchronous to the block's own fast clock, which oversamples them. Each pin goes through a synchronizer, and edges on the synchronized levels are found by comparing each level with its value one cycle earlier. A polarity bit can invert every data input. In single-rail mode the block does no line coding of its own. It samples the data bit and forwards it, so that an external coder can produce the pulses. After reset, and after any change of format, the block waits until the synchronizer is full before it accepts an event. Until then it signals a space.

Top module: `tx_rail_intf`

## Requirements
- R1: After reset `pos_pulse`, `neg_pulse`, `nrz_bit` and `sample_stb` are all 0, and they stay 0 until the first accepted sample.
- R2: In dual-rail NRZ format (`cfg_fmt` = 1), each active clock edge loads a command from the polarity-corrected rails (P, N). P=1,N=0 gives `pos_pulse`=1. P=0,N=1 gives `neg_pulse`=1. P=N=0 and P=N=1 both give a space (both 0). The command is held until the next active edge, whatever the rails do in between.
- R3: `pos_pulse` and `neg_pulse` are never 1 in the same cycle.
- R4: With `cfg_edge_fall`=0 the rising edge of `txclk_or_n` is the active edge, and with 1 the falling edge is. The opposite edge changes no output and raises no strobe.
- R5: With `cfg_invert`=1 every data input is complemented before use, in all three formats. In RZ format this also makes a low level the active level.
- R6: In single-rail NRZ format (`cfg_fmt` = 0), each active edge loads `nrz_bit` with `txd_p` XOR `cfg_invert`, and `pos_pulse`/`neg_pulse` stay 0.
- R7: In dual-rail RZ format (`cfg_fmt` = 2), `txclk_or_n` is the negative rail and `txd_n` has no effect. `pos_pulse`/`neg_pulse` follow the R2 mapping of the active rail levels on every cycle. `sample_stb` is 1 for one cycle when either rail turns active. `cfg_edge_fall` has no effect.
- R8: In the NRZ formats `sample_stb` is 1 for exactly one cycle per accepted active edge.
- R9: A pin change is seen at the outputs after SYNC_STAGES+1 rising edges of `clk`, and not before.
- R10: A change of `cfg_fmt` clears `pos_pulse`, `neg_pulse`, `nrz_bit` and `sample_stb` on the next cycle. Events are then ignored for SYNC_STAGES+1 cycles.
- R11: `cfg_fmt` = 3 is reserved. While it is selected, all outputs stay 0 whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fmt | input | 2 | Format: 0 single NRZ, 1 dual NRZ, 2 dual RZ, 3 reserved |
| cfg_invert | input | 1 | Complement all data inputs |
| cfg_edge_fall | input | 1 | Sample on falling (1) or rising (0) clock edge |
| txd_p | input | 1 | Single-rail data, or positive rail |
| txd_n | input | 1 | Negative rail in dual-rail NRZ format |
| txclk_or_n | input | 1 | Transmit clock (NRZ formats) or negative rail (RZ format) |
| pos_pulse | output | 1 | Command: positive pulse on tip |
| neg_pulse | output | 1 | Command: negative pulse on tip |
| nrz_bit | output | 1 | Sampled single-rail bit for external coding |
| sample_stb | output | 1 | One-cycle mark of an accepted event |

## Verification
The dual-rail NRZ mapping is swept over all four rail pairs, for each polarity and each sampling edge. This separates the two space codes from the two pulse codes, and it shows whether the inversion acts before the mapping. Between active edges the rails are changed and the opposite clock edge is applied, with the outputs watched each cycle. That exposes any update on the wrong edge and any output that does not hold. The single-rail sweep covers both bit values under both polarities and both edges. The RZ sweep drives all rail pairs with the unused NRZ pin toggling, and it confirms the return to space once the rails go idle. Format switches, including into the reserved code, check the clearing and the silence after them.

// File: rtl/tx_rail_pkg.sv
package tx_rail_pkg;

    typedef enum logic [1:0] {
        FMT_SR_NRZ = 2'd0,
        FMT_DR_NRZ = 2'd1,
        FMT_DR_RZ  = 2'd2,
        FMT_RSVD   = 2'd3
    } tx_fmt_e;

    typedef enum logic [1:0] {
        CMD_SPACE = 2'd0,
        CMD_POS   = 2'd1,
        CMD_NEG   = 2'd2
    } line_cmd_e;

    // Pin vector positions
    localparam int PIN_P    = 0;
    localparam int PIN_N    = 1;
    localparam int PIN_CN   = 2;
    localparam int NUM_PINS = 3;

    // Rail pair to command; equal rails are a space
    function automatic line_cmd_e rail_to_cmd(input logic p, input logic n);
        line_cmd_e c;
        unique case ({p, n})
            2'b10:   c = CMD_POS;
            2'b01:   c = CMD_NEG;
            default: c = CMD_SPACE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tx_pin_sync.sv
module tx_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[LAST];

endmodule

// File: rtl/tx_edge_detect.sv
module tx_edge_detect #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            assign rise[g] =  lvl[g] & ~prev_q[g];
            assign fall[g] = ~lvl[g] &  prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/tx_rail_decode.sv
module tx_rail_decode
    import tx_rail_pkg::*;
(
    input  tx_fmt_e              fmt,
    input  logic                 invert,
    input  logic                 edge_fall,
    input  logic [NUM_PINS-1:0]  lvl,
    input  logic [NUM_PINS-1:0]  rise,
    input  logic [NUM_PINS-1:0]  fall,
    output logic                 ev,
    output line_cmd_e            cmd,
    output logic                 bit_o
);
    logic [NUM_PINS-1:0] act;
    logic [NUM_PINS-1:0] act_go;
    logic                clk_edge;

    always_comb begin
        act      = lvl ^ {NUM_PINS{invert}};
        act_go   = invert ? fall : rise;
        clk_edge = edge_fall ? fall[PIN_CN] : rise[PIN_CN];
        ev       = 1'b0;
        cmd      = CMD_SPACE;
        bit_o    = 1'b0;
        unique case (fmt)
            FMT_SR_NRZ: begin
                ev    = clk_edge;
                bit_o = act[PIN_P];
            end
            FMT_DR_NRZ: begin
                ev  = clk_edge;
                cmd = rail_to_cmd(act[PIN_P], act[PIN_N]);
            end
            FMT_DR_RZ: begin
                ev  = act_go[PIN_P] | act_go[PIN_CN];
                cmd = rail_to_cmd(act[PIN_P], act[PIN_CN]);
            end
            default: begin
                ev  = 1'b0;
                cmd = CMD_SPACE;
            end
        endcase
    end

endmodule

// File: rtl/tx_rail_intf.sv
module tx_rail_intf
    import tx_rail_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_fmt,
    input  logic       cfg_invert,
    input  logic       cfg_edge_fall,
    input  logic       txd_p,
    input  logic       txd_n,
    input  logic       txclk_or_n,
    output logic       pos_pulse,
    output logic       neg_pulse,
    output logic       nrz_bit,
    output logic       sample_stb
);
    localparam int WARM   = SYNC_STAGES + 1;
    localparam int WARM_W = $clog2(WARM + 1);

    typedef struct packed {
        logic              pos;
        logic              neg;
        logic              nrz;
        logic              stb;
        tx_fmt_e           fmt;
        logic [WARM_W-1:0] warm;
    } state_t;

    tx_fmt_e             fmt_w;
    logic [NUM_PINS-1:0] pins_raw;
    logic [NUM_PINS-1:0] pins_s;
    logic [NUM_PINS-1:0] rise_w;
    logic [NUM_PINS-1:0] fall_w;
    logic                ev_w;
    line_cmd_e           cmd_w;
    logic                bit_w;
    logic                armed_w;
    state_t              d, q;

    assign fmt_w    = tx_fmt_e'(cfg_fmt);
    assign pins_raw = {txclk_or_n, txd_n, txd_p};

    tx_pin_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s)
    );

    tx_edge_detect #(.W(NUM_PINS)) edge_i (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (pins_s),
        .rise (rise_w),
        .fall (fall_w)
    );

    tx_rail_decode dec_i (
        .fmt      (q.fmt),
        .invert   (cfg_invert),
        .edge_fall(cfg_edge_fall),
        .lvl      (pins_s),
        .rise     (rise_w),
        .fall     (fall_w),
        .ev       (ev_w),
        .cmd      (cmd_w),
        .bit_o    (bit_w)
    );

    assign armed_w = (q.warm == WARM_W'(WARM));

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (fmt_w != q.fmt) begin
            d.fmt  = fmt_w;
            d.pos  = 1'b0;
            d.neg  = 1'b0;
            d.nrz  = 1'b0;
            d.warm = '0;
        end else if (!armed_w) begin
            d.warm = q.warm + WARM_W'(1);
        end else begin
            unique case (q.fmt)
                FMT_SR_NRZ, FMT_DR_NRZ: begin
                    if (ev_w) begin
                        d.pos = (cmd_w == CMD_POS);
                        d.neg = (cmd_w == CMD_NEG);
                        d.nrz = bit_w;
                        d.stb = 1'b1;
                    end
                end
                FMT_DR_RZ: begin
                    d.pos = (cmd_w == CMD_POS);
                    d.neg = (cmd_w == CMD_NEG);
                    d.nrz = 1'b0;
                    d.stb = ev_w;
                end
                default: begin
                    d.pos = 1'b0;
                    d.neg = 1'b0;
                    d.nrz = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pos  <= 1'b0;
            q.neg  <= 1'b0;
            q.nrz  <= 1'b0;
            q.stb  <= 1'b0;
            q.fmt  <= FMT_SR_NRZ;
            q.warm <= '0;
        end else begin
            q <= d;
        end
    end

    assign pos_pulse  = q.pos;
    assign neg_pulse  = q.neg;
    assign nrz_bit    = q.nrz;
    assign sample_stb = q.stb;

    assert_excl_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_pulse && neg_pulse));

    assert_nrz_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fmt == FMT_DR_NRZ && $past(q.fmt) == FMT_DR_NRZ && !sample_stb)
        |-> ($stable(pos_pulse) && $stable(neg_pulse)));

    assert_single_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fmt == FMT_SR_NRZ) |-> (!pos_pulse && !neg_pulse));

    assert_stb_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && q.fmt != FMT_DR_RZ) |=> !sample_stb);

    assert_fmt_change_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_w != q.fmt) |=> (!pos_pulse && !neg_pulse && !nrz_bit && !sample_stb));

    assert_reserved_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_w == FMT_RSVD && q.fmt == FMT_RSVD)
        |-> (!pos_pulse && !neg_pulse && !nrz_bit && !sample_stb));

endmodule

// File: tb/tx_rail_intf_tb.sv
module tx_rail_intf_tb_top;

    localparam int SYNC_STAGES = 2;
    localparam int LAT         = SYNC_STAGES + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_fmt = 2'd1;
    logic       cfg_invert = 1'b0;
    logic       cfg_edge_fall = 1'b0;
    logic       txd_p = 1'b0;
    logic       txd_n = 1'b0;
    logic       txclk_or_n = 1'b0;
    logic       pos_pulse, neg_pulse, nrz_bit, sample_stb;

    int checks = 0;
    int fails  = 0;
    logic exp_pos = 1'b0, exp_neg = 1'b0, exp_nrz = 1'b0;

    always #10 clk = ~clk;

    tx_rail_intf #(.SYNC_STAGES(SYNC_STAGES)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_invert(cfg_invert),
        .cfg_edge_fall(cfg_edge_fall), .txd_p(txd_p), .txd_n(txd_n),
        .txclk_or_n(txclk_or_n), .pos_pulse(pos_pulse), .neg_pulse(neg_pulse),
        .nrz_bit(nrz_bit), .sample_stb(sample_stb)
    );

    // observed vector: {pos, neg, nrz, stb}
    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b (pos,neg,nrz,stb)", req, act, exp);
        end
    endtask

    function automatic logic [3:0] obs();
        return {pos_pulse, neg_pulse, nrz_bit, sample_stb};
    endfunction

    // Change the format and check the clearing one cycle later
    task automatic set_fmt(input logic [1:0] f);
        @(negedge clk);
        cfg_fmt = f;
        @(posedge clk); #1;
        check("R10 clear on format change", obs(), 4'b0000);
        exp_pos = 1'b0; exp_neg = 1'b0; exp_nrz = 1'b0;
        repeat (LAT + 3) @(posedge clk);
    endtask

    // One NRZ bit: inactive edge and new data first, then active edge
    task automatic nrz_step(input logic p, input logic n, input logic esel,
                            input logic inv, input logic dual);
        logic act_lvl;
        logic seen;
        act_lvl = ~esel;
        @(negedge clk);
        cfg_edge_fall = esel;
        cfg_invert    = inv;
        txd_p         = p;
        txd_n         = n;
        txclk_or_n    = ~act_lvl;
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            seen = seen | sample_stb;
        end
        check("R4 R2 hold across inactive edge", {obs()[3:1], seen},
              {exp_pos, exp_neg, exp_nrz, 1'b0});
        @(negedge clk);
        txclk_or_n = act_lvl;
        repeat (LAT - 1) @(posedge clk); #1;
        check("R9 no update before latency", {1'b0, 1'b0, 1'b0, sample_stb}, 4'b0000);
        @(posedge clk); #1;
        if (dual) begin
            exp_pos = (p ^ inv) & ~(n ^ inv);
            exp_neg = (n ^ inv) & ~(p ^ inv);
            exp_nrz = 1'b0;
            check("R2 R5 R4 dual NRZ sample", obs(), {exp_pos, exp_neg, exp_nrz, 1'b1});
        end else begin
            exp_pos = 1'b0;
            exp_neg = 1'b0;
            exp_nrz = p ^ inv;
            check("R6 R5 R4 single NRZ sample", obs(), {exp_pos, exp_neg, exp_nrz, 1'b1});
        end
        @(posedge clk); #1;
        check("R8 strobe lasts one cycle", obs(), {exp_pos, exp_neg, exp_nrz, 1'b0});
    endtask

    task automatic rz_idle(input logic inv, input logic esel);
        @(negedge clk);
        cfg_invert    = inv;
        cfg_edge_fall = esel;
        txd_p         = inv;
        txclk_or_n    = inv;
        repeat (LAT + 3) @(posedge clk);
    endtask

    task automatic rz_step(input logic p, input logic n, input logic inv);
        @(negedge clk);
        txd_p      = p ? ~inv : inv;
        txclk_or_n = n ? ~inv : inv;
        txd_n      = ~txd_n;
        repeat (LAT) @(posedge clk); #1;
        check("R7 R5 RZ rail activation", obs(),
              {p & ~n, n & ~p, 1'b0, p | n});
        @(negedge clk);
        txd_p      = inv;
        txclk_or_n = inv;
        txd_n      = ~txd_n;
        repeat (LAT) @(posedge clk); #1;
        check("R7 RZ return to space", obs(), 4'b0000);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 outputs in reset", obs(), 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (LAT + 4) @(posedge clk); #1;
        check("R1 idle after reset", obs(), 4'b0000);

        // Dual-rail NRZ sweep
        for (int e = 0; e < 2; e++)
            for (int v = 0; v < 2; v++)
                for (int pat = 0; pat < 4; pat++)
                    nrz_step(pat[1], pat[0], e[0], v[0], 1'b1);
        nrz_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

        // Single-rail NRZ sweep
        set_fmt(2'd0);
        for (int e = 0; e < 2; e++)
            for (int v = 0; v < 2; v++)
                for (int b = 0; b < 2; b++)
                    nrz_step(b[0], ~b[0], e[0], v[0], 1'b0);
        nrz_step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

        // Dual-rail RZ sweep
        set_fmt(2'd2);
        for (int v = 0; v < 2; v++)
            for (int e = 0; e < 2; e++) begin
                rz_idle(v[0], e[0]);
                for (int pat = 0; pat < 4; pat++)
                    rz_step(pat[1], pat[0], v[0]);
            end

        // Reserved format: no output whatever the pins do
        rz_idle(1'b0, 1'b0);
        rz_step(1'b1, 1'b0, 1'b0);
        set_fmt(2'd3);
        begin
            logic [3:0] acc;
            acc = 4'b0000;
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                txclk_or_n = ~txclk_or_n;
                txd_p      = i[1];
                txd_n      = i[2];
                @(posedge clk); #1;
                acc = acc | obs();
            end
            repeat (LAT) @(posedge clk); #1;
            acc = acc | obs();
            check("R11 reserved format stays silent", acc, 4'b0000);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule